// File: doc/BRIEF.md
# Burst Header Offset Rewriter

This block sits on the control path of an optical burst switch. A burst header arrives ahead of its data burst. The header carries an offset: the time from the header's first bit to the burst's first bit. The header also names the data channel the burst came in on, the outgoing channel picked for it, an optional buffering delay and a flag that says whether the burst was buffered. The data channels pass through a fixed-length delay and are never inspected. The block therefore keeps control and data aligned by arithmetic alone.

When a header is accepted, the block stamps it with the free-running local time `now_time`. It then folds four terms into the offset: the received offset, a signed per-input-channel skew correction read from a writable table, the fixed data-path delay and, for buffered bursts, the queueing delay. While the header waits for the output, the time spent inside the block is the current time minus the stamp, computed modulo the counter width. That time is subtracted continuously, so the offset shown on the output is correct for the cycle in which the header leaves. A header whose offset is still above the limit is held back until enough time has passed. A header whose offset has gone below zero is too late for its burst and is discarded, with a one-cycle flag.

The block holds one header at a time. Order is kept through valid/ready handshakes on both sides.

Top module: `burst_offset_rewriter`

## Requirements
- R1: While a header is held, its output offset falls by exactly one for each unit that `now_time` advances. The internal delay is `now_time` minus the arrival stamp taken at the accepting clock edge.
- R2: The forwarded offset equals received offset + skew[input channel] + FIXED_DELAY + queueing term − internal delay (default FIXED_DELAY = 200).
- R3: The queueing term equals `hdr_in_qdelay` when `hdr_in_buffered` is 1, and zero when it is 0. With the flag at 0, the value on `hdr_in_qdelay` has no effect on the output offset.
- R4: The skew table has one signed 12-bit two's-complement entry per input channel (16 entries, indexed by `hdr_in_chan`). All entries are 0 after reset. A write with `cfg_we` high stores `cfg_skew` at `cfg_chan` on that clock edge.
- R5: While the recomputed offset exceeds MAX_OFFSET (default 1000), `hdr_out_valid` stays low and the header is kept. It is offered as soon as the offset is at or below the limit, including exactly equal to it.
- R6: When the recomputed offset is below zero, `late_drop` is high for one cycle, `hdr_out_valid` stays low, and the slot is free after that edge. An offset of exactly zero is forwarded.
- R7: `hdr_out_chan` carries the outgoing channel supplied with the header (`hdr_in_out_chan`), not the input channel.
- R8: Only one header is held at a time. `hdr_in_ready` is low while a header is held. The header leaves on a clock edge with `hdr_out_valid` and `hdr_out_ready` both high. Headers leave in arrival order, and a stalled header keeps its channel.
- R9: After reset, `hdr_in_ready` is 1 and both `hdr_out_valid` and `late_drop` are 0.
- R10: The internal delay is taken modulo 2^16, so a stamp near the top of the time range followed by a wrapped `now_time` gives the true short delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_in_valid | input | 1 | Incoming header present |
| hdr_in_ready | output | 1 | Block can take a header |
| hdr_in_offset | input | 16 | Received header-to-burst offset |
| hdr_in_chan | input | 4 | Input data channel of the burst (skew table index) |
| hdr_in_out_chan | input | 4 | Outgoing data channel chosen for the burst |
| hdr_in_qdelay | input | 16 | Queueing delay of a buffered burst |
| hdr_in_buffered | input | 1 | Burst was buffered; add the queueing delay |
| now_time | input | 16 | Free-running local time |
| cfg_we | input | 1 | Skew table write strobe |
| cfg_chan | input | 4 | Skew table entry to write |
| cfg_skew | input | 12 | Signed skew correction to store |
| hdr_out_valid | output | 1 | Rewritten header offered |
| hdr_out_ready | input | 1 | Downstream takes the header |
| hdr_out_offset | output | 16 | Rewritten offset for the current cycle |
| hdr_out_chan | output | 4 | Outgoing data channel |
| late_drop | output | 1 | Held header is late and is discarded at this edge |

## Verification
A header is captured on the clock edge that accepts it. Its offset, `hdr_out_valid` and `late_drop` then follow from the held record and the present `now_time` in the next cycle, with no further register on the way. The slot is seen free one edge after the transfer or drop. The bench drives a new `now_time` just after the accepting edge and samples the outputs a few nanoseconds later, well before the following edge. It checks `hdr_in_ready` just after the edge that should release the slot. Stall and hold tests advance `now_time` one step per cycle so that the one-unit decrease of R1 and the exact crossing of the limit in R5 land in known cycles.

// File: rtl/bor_pkg.sv
`timescale 1ns/1ps
package bor_pkg;

    // widths shared by every stage of the rewriter
    localparam int TIME_W = 16;              // time counter, offsets, delays
    localparam int SKEW_W = 12;              // signed skew correction
    localparam int CHAN_W = 4;               // data channel number
    localparam int NCHAN  = 1 << CHAN_W;     // skew table entries
    localparam int CALC_W = TIME_W + 3;      // signed headroom for sums of four terms

    // record kept for the one header in flight
    typedef struct packed {
        logic                     full;
        logic [TIME_W-1:0]        stamp;
        logic signed [CALC_W-1:0] base;      // offset with every additive term folded in
        logic [CHAN_W-1:0]        out_chan;
    } held_t;

    // standing of the held header in the current cycle
    typedef enum logic [1:0] {
        HOLD_EMPTY,
        HOLD_WAIT,
        HOLD_READY,
        HOLD_LATE
    } hold_state_e;

endpackage

// File: rtl/bor_skew_table.sv
`timescale 1ns/1ps
module bor_skew_table
    import bor_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CHAN_W-1:0]        wr_chan,
    input  logic signed [SKEW_W-1:0] wr_skew,
    input  logic [CHAN_W-1:0]        rd_chan,
    output logic signed [SKEW_W-1:0] rd_skew
);

    logic signed [SKEW_W-1:0] skew_q [NCHAN];
    logic signed [SKEW_W-1:0] skew_d [NCHAN];

    // one comparator per entry decides whether that entry takes the write
    for (genvar g = 0; g < NCHAN; g++) begin : g_entry
        always_comb begin
            skew_d[g] = skew_q[g];
            if (wr_en && (wr_chan == CHAN_W'(g))) begin
                skew_d[g] = wr_skew;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                skew_q[g] <= '0;
            end else begin
                skew_q[g] <= skew_d[g];
            end
        end
    end

    assign rd_skew = skew_q[rd_chan];

    // R4: a write is visible in its entry after the edge
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (skew_q[$past(wr_chan)] == $past(wr_skew)));

endmodule

// File: rtl/bor_stamp_stage.sv
`timescale 1ns/1ps
module bor_stamp_stage
    import bor_pkg::*;
#(
    parameter int FIXED_DELAY = 200
) (
    input  logic [TIME_W-1:0]        offset_in,
    input  logic [TIME_W-1:0]        qdelay_in,
    input  logic                     buffered_in,
    input  logic [CHAN_W-1:0]        out_chan_in,
    input  logic signed [SKEW_W-1:0] skew_in,
    input  logic [TIME_W-1:0]        now_time,
    output held_t                    rec_out
);

    localparam int PAD_T = CALC_W - TIME_W;
    localparam int PAD_S = CALC_W - SKEW_W;
    localparam logic signed [CALC_W-1:0] FIXED_C = CALC_W'(FIXED_DELAY);

    logic signed [CALC_W-1:0] off_ext;
    logic signed [CALC_W-1:0] skew_ext;
    logic signed [CALC_W-1:0] queue_ext;

    always_comb begin
        off_ext   = $signed({{PAD_T{1'b0}}, offset_in});
        skew_ext  = $signed({{PAD_S{skew_in[SKEW_W-1]}}, skew_in});
        queue_ext = buffered_in ? $signed({{PAD_T{1'b0}}, qdelay_in}) : '0;

        rec_out          = '0;
        rec_out.full     = 1'b1;
        rec_out.stamp    = now_time;
        rec_out.base     = off_ext + skew_ext + FIXED_C + queue_ext;
        rec_out.out_chan = out_chan_in;
    end

endmodule

// File: rtl/bor_hold_stage.sv
`timescale 1ns/1ps
module bor_hold_stage
    import bor_pkg::*;
#(
    parameter int MAX_OFFSET = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  held_t               rec_in,
    input  logic [TIME_W-1:0]   now_time,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [TIME_W-1:0]   out_offset,
    output logic [CHAN_W-1:0]   out_chan,
    output logic                late
);

    localparam int PAD_T = CALC_W - TIME_W;
    localparam logic signed [CALC_W-1:0] MAX_C = CALC_W'(MAX_OFFSET);

    held_t                    hold_q, hold_d;
    hold_state_e              state;
    logic [TIME_W-1:0]        elapsed;
    logic signed [CALC_W-1:0] cur;

    always_comb begin
        // internal delay wraps with the time counter
        elapsed = now_time - hold_q.stamp;
        cur     = hold_q.base - $signed({{PAD_T{1'b0}}, elapsed});

        if (!hold_q.full) begin
            state = HOLD_EMPTY;
        end else if (cur < 0) begin
            state = HOLD_LATE;
        end else if (cur > MAX_C) begin
            state = HOLD_WAIT;
        end else begin
            state = HOLD_READY;
        end

        in_ready   = (state == HOLD_EMPTY);
        out_valid  = (state == HOLD_READY);
        late       = (state == HOLD_LATE);
        out_offset = cur[TIME_W-1:0];
        out_chan   = hold_q.out_chan;

        hold_d = hold_q;
        unique case (state)
            HOLD_EMPTY: if (in_valid) hold_d = rec_in;
            HOLD_LATE:  hold_d.full = 1'b0;
            HOLD_READY: if (out_ready) hold_d.full = 1'b0;
            HOLD_WAIT:  hold_d = hold_q;
            default:    hold_d = hold_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R5: an offered offset never exceeds the limit
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_offset) <= MAX_OFFSET));

    // R6: a late header frees the slot at the next edge
    p_late_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        late |=> in_ready);

    // R8: an accepted header blocks the input in the following cycle
    p_accept_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: a stalled header stays, with the same channel
    p_stall_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!in_ready && $stable(out_chan)));

    // R1: one unit of time costs one unit of offset while held
    p_decay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid && !out_ready) && out_valid &&
         (now_time == $past(now_time) + 16'd1))
        |-> (out_offset == $past(out_offset) - 16'd1));

endmodule

// File: rtl/burst_offset_rewriter.sv
`timescale 1ns/1ps
module burst_offset_rewriter
    import bor_pkg::*;
#(
    parameter int FIXED_DELAY = 200,
    parameter int MAX_OFFSET  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_in_valid,
    output logic              hdr_in_ready,
    input  logic [15:0]       hdr_in_offset,
    input  logic [3:0]        hdr_in_chan,
    input  logic [3:0]        hdr_in_out_chan,
    input  logic [15:0]       hdr_in_qdelay,
    input  logic              hdr_in_buffered,
    input  logic [15:0]       now_time,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_chan,
    input  logic [11:0]       cfg_skew,
    output logic              hdr_out_valid,
    input  logic              hdr_out_ready,
    output logic [15:0]       hdr_out_offset,
    output logic [3:0]        hdr_out_chan,
    output logic              late_drop
);

    logic signed [SKEW_W-1:0] skew_rd;
    held_t                    rec;

    bor_skew_table i_skew (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_chan (cfg_chan),
        .wr_skew ($signed(cfg_skew)),
        .rd_chan (hdr_in_chan),
        .rd_skew (skew_rd)
    );

    bor_stamp_stage #(
        .FIXED_DELAY (FIXED_DELAY)
    ) i_stamp (
        .offset_in   (hdr_in_offset),
        .qdelay_in   (hdr_in_qdelay),
        .buffered_in (hdr_in_buffered),
        .out_chan_in (hdr_in_out_chan),
        .skew_in     (skew_rd),
        .now_time    (now_time),
        .rec_out     (rec)
    );

    bor_hold_stage #(
        .MAX_OFFSET (MAX_OFFSET)
    ) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (hdr_in_valid),
        .in_ready   (hdr_in_ready),
        .rec_in     (rec),
        .now_time   (now_time),
        .out_valid  (hdr_out_valid),
        .out_ready  (hdr_out_ready),
        .out_offset (hdr_out_offset),
        .out_chan   (hdr_out_chan),
        .late       (late_drop)
    );

    // R6: a late header is never offered in the same cycle
    p_late_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        late_drop |-> !hdr_out_valid);

endmodule

// File: tb/test_burst_offset_rewriter.sv
`timescale 1ns/1ps
module test_burst_offset_rewriter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_in_valid = 1'b0;
    logic        hdr_in_ready;
    logic [15:0] hdr_in_offset = '0;
    logic [3:0]  hdr_in_chan = '0;
    logic [3:0]  hdr_in_out_chan = '0;
    logic [15:0] hdr_in_qdelay = '0;
    logic        hdr_in_buffered = 1'b0;
    logic [15:0] now_time = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_chan = '0;
    logic [11:0] cfg_skew = '0;
    logic        hdr_out_valid;
    logic        hdr_out_ready = 1'b0;
    logic [15:0] hdr_out_offset;
    logic [3:0]  hdr_out_chan;
    logic        late_drop;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_offset_rewriter i_burst_offset_rewriter (
        .clk             (clk),
        .rst_n           (rst_n),
        .hdr_in_valid    (hdr_in_valid),
        .hdr_in_ready    (hdr_in_ready),
        .hdr_in_offset   (hdr_in_offset),
        .hdr_in_chan     (hdr_in_chan),
        .hdr_in_out_chan (hdr_in_out_chan),
        .hdr_in_qdelay   (hdr_in_qdelay),
        .hdr_in_buffered (hdr_in_buffered),
        .now_time        (now_time),
        .cfg_we          (cfg_we),
        .cfg_chan        (cfg_chan),
        .cfg_skew        (cfg_skew),
        .hdr_out_valid   (hdr_out_valid),
        .hdr_out_ready   (hdr_out_ready),
        .hdr_out_offset  (hdr_out_offset),
        .hdr_out_chan    (hdr_out_chan),
        .late_drop       (late_drop)
    );

    typedef struct packed {
        logic [15:0] off;
        logic [3:0]  ch;
        logic [3:0]  och;
        logic [15:0] q;
        logic        bufd;
        logic [15:0] tin;
        logic [15:0] tout;
        logic        fwd;
        logic [15:0] exp;
    } vec_t;

    // skew: ch2 = +37, ch5 = -100, ch15 = -2048, others 0; fixed 200, limit 1000
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd100,  4'd0,  4'd3,  16'd50,  1'b0, 16'd10,    16'd15,  1'b1, 16'd295}, // R3 flag off
        '{16'd100,  4'd0,  4'd4,  16'd50,  1'b1, 16'd20,    16'd21,  1'b1, 16'd349}, // R3 flag on
        '{16'd300,  4'd2,  4'd7,  16'd0,   1'b0, 16'd100,   16'd110, 1'b1, 16'd527}, // R4 positive
        '{16'd500,  4'd5,  4'd1,  16'd120, 1'b1, 16'd200,   16'd300, 1'b1, 16'd620}, // R4 negative
        '{16'd0,    4'd0,  4'd9,  16'd0,   1'b0, 16'd50,    16'd250, 1'b1, 16'd0},   // R6 zero kept
        '{16'd0,    4'd0,  4'd9,  16'd0,   1'b0, 16'd50,    16'd251, 1'b0, 16'd0},   // R6 late
        '{16'd800,  4'd0,  4'd10, 16'd0,   1'b0, 16'd1000,  16'd1000,1'b1, 16'd1000},// R5 at limit
        '{16'd10,   4'd0,  4'd11, 16'd0,   1'b0, 16'd65530, 16'd4,   1'b1, 16'd200}, // R10 wrap
        '{16'd2000, 4'd15, 4'd2,  16'd0,   1'b0, 16'd0,     16'd100, 1'b1, 16'd52},  // R4 extreme
        '{16'd100,  4'd7,  4'd0,  16'd0,   1'b0, 16'd5,     16'd6,   1'b1, 16'd299}  // R4 reset zero
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic write_skew(input logic [3:0] ch, input logic [11:0] val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_chan = ch;
        cfg_skew = val;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic offer(input logic [15:0] off, input logic [3:0] ch, input logic [3:0] och,
                         input logic [15:0] q, input logic bufd, input logic [15:0] t);
        hdr_in_valid    = 1'b1;
        hdr_in_offset   = off;
        hdr_in_chan     = ch;
        hdr_in_out_chan = och;
        hdr_in_qdelay   = q;
        hdr_in_buffered = bufd;
        now_time        = t;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        offer(v.off, v.ch, v.och, v.q, v.bufd, v.tin);
        hdr_out_ready = 1'b0;
        @(posedge clk);
        #1;
        hdr_in_valid  = 1'b0;
        now_time      = v.tout;
        hdr_out_ready = 1'b1;
        #1;
        if (v.fwd) begin
            chk("R2", $sformatf("vec%0d valid", idx), int'(hdr_out_valid), 1);
            chk("R2", $sformatf("vec%0d offset", idx), int'(hdr_out_offset), int'(v.exp));
            chk("R7", $sformatf("vec%0d out_chan", idx), int'(hdr_out_chan), int'(v.och));
        end else begin
            chk("R6", $sformatf("vec%0d late_drop", idx), int'(late_drop), 1);
            chk("R6", $sformatf("vec%0d valid", idx), int'(hdr_out_valid), 0);
        end
        @(posedge clk);
        #1;
        chk("R8", $sformatf("vec%0d slot free", idx), int'(hdr_in_ready), 1);
        chk("R6", $sformatf("vec%0d late cleared", idx), int'(late_drop), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9", "in_ready in reset", int'(hdr_in_ready), 1);
        chk("R9", "out_valid in reset", int'(hdr_out_valid), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9", "in_ready after reset", int'(hdr_in_ready), 1);
        chk("R9", "late after reset", int'(late_drop), 0);

        // R4: program the skew table
        write_skew(4'd2, 12'd37);
        write_skew(4'd5, 12'hF9C);
        write_skew(4'd15, 12'h800);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // R5: held above the limit, released exactly at it
        @(negedge clk);
        offer(16'd1000, 4'd0, 4'd5, 16'd400, 1'b1, 16'd300);
        hdr_out_ready = 1'b1;
        @(posedge clk);
        #1;
        hdr_in_valid = 1'b0;
        now_time = 16'd301;
        #1;
        chk("R5", "1599 withheld", int'(hdr_out_valid), 0);
        chk("R5", "1599 not late", int'(late_drop), 0);
        chk("R8", "held blocks input", int'(hdr_in_ready), 0);
        @(negedge clk);
        now_time = 16'd899;
        #1;
        chk("R5", "1001 withheld", int'(hdr_out_valid), 0);
        @(negedge clk);
        now_time = 16'd900;
        #1;
        chk("R5", "1000 offered", int'(hdr_out_valid), 1);
        chk("R5", "1000 offset", int'(hdr_out_offset), 1000);
        @(posedge clk);
        #1;
        chk("R5", "released slot free", int'(hdr_in_ready), 1);

        // R8 / R1: stall with a second header waiting
        @(negedge clk);
        offer(16'd100, 4'd0, 4'd6, 16'd0, 1'b0, 16'd400);
        hdr_out_ready = 1'b0;
        @(posedge clk);
        #1;
        offer(16'd50, 4'd0, 4'd8, 16'd0, 1'b0, 16'd401);
        #1;
        chk("R2", "stalled offset", int'(hdr_out_offset), 299);
        chk("R8", "second header blocked", int'(hdr_in_ready), 0);
        @(negedge clk);
        now_time = 16'd402;
        #1;
        chk("R1", "offset after one step", int'(hdr_out_offset), 298);
        chk("R8", "stalled channel kept", int'(hdr_out_chan), 6);
        chk("R8", "still offered", int'(hdr_out_valid), 1);
        hdr_out_ready = 1'b1;
        @(posedge clk);
        #1;
        chk("R8", "first gone, slot free", int'(hdr_in_ready), 1);
        @(posedge clk);
        #1;
        hdr_in_valid = 1'b0;
        now_time = 16'd403;
        #1;
        chk("R8", "second header in order", int'(hdr_out_chan), 8);
        chk("R2", "second header offset", int'(hdr_out_offset), 249);
        @(posedge clk);
        #1;
        chk("R8", "second gone", int'(hdr_in_ready), 1);
        chk("R8", "nothing offered", int'(hdr_out_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule